// File: doc/BRIEF.md
# Output Compare Unit with Byte-Pair Write Guard

This block holds a 16-bit compare value and checks it against an external free-running counter. The counter and its advance strobe are inputs. When the two are equal on a clock in which the counter advances, the block sets a compare flag and loads a level bit chosen by software into a registered output pin. If the interrupt enable is set, it also raises an interrupt request.

An 8-bit bus loads the compare value one byte at a time. A high-byte write stops all matching until the matching low-byte write arrives. This keeps a half-updated value from firing a false match. A low-byte write made on its own never stops matching.

Software clears the flag in two steps. It reads the status while the flag is set, then writes the compare low byte. A match in the same cycle as that write takes priority, and the flag stays set.

Top module: `ocmp_unit`

## Requirements
- R1: Each compare byte can be written and read back on its own. `wr_hi`=1 selects the high byte and `wr_hi`=0 selects the low byte. A write to one byte leaves the other byte unchanged.
- R2: Reset clears the flag, the output level pin, the level bit, the interrupt enable and the write guard. Reset does not change the compare bytes.
- R3: When `cnt_tick` is high, the guard is released and `cnt_value` equals the compare value, `cmp_flag` is 1 from the next clock. On that same clock, `level_out` takes the level bit.
- R4: When `cnt_tick` is low, equality between counter and compare value has no effect on `cmp_flag` or `level_out`.
- R5: The level bit is copied to `level_out` on every match, including a match that happens while `cmp_flag` is already set.
- R6: After a high-byte write, no match occurs until a low-byte write has completed the pair.
- R7: A low-byte write without a preceding high-byte write does not stop matching.
- R8: `irq` is 1 exactly when `cmp_flag` and the interrupt enable are both 1.
- R9: `cmp_flag` clears on a low-byte write only if `stat_rd` was pulsed while the flag was set and before that write. A low-byte write without that read leaves the flag set.
- R10: When a match and a clearing low-byte write fall in the same cycle, the flag stays set.
- R11: A pulse on `ctl_wr` loads `ctl_data` bit 0 as the level bit and `ctl_data` bit 1 as the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_value | input | 16 | Free-running counter value |
| cnt_tick | input | 1 | High in the clock where the counter takes a new value |
| wr_en | input | 1 | Compare byte write strobe |
| wr_hi | input | 1 | 1 selects the high byte, 0 selects the low byte |
| wr_data | input | 8 | Byte to write |
| ctl_wr | input | 1 | Control write strobe |
| ctl_data | input | 2 | Bit 0 is the level bit, bit 1 is the interrupt enable |
| stat_rd | input | 1 | Status read strobe, arms the flag clear |
| rd_hi | output | 8 | Compare high byte |
| rd_lo | output | 8 | Compare low byte |
| cmp_flag | output | 1 | Compare flag |
| level_out | output | 1 | Registered output level pin |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked by assertions on every cycle. No match event fires without a counter advance or while the write guard is held. The flag never rises without a match. After every match the output pin holds the level bit and the flag is set, whatever the clear sequence did in that cycle.

Other behaviour can only be shown by the bench's scenarios. These are byte independence on readback, compare bytes surviving reset, the full guard sequence across a split write, and the two-step clear with and without its status read.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
    localparam int BYTE_W = 8;
    localparam int CMP_W  = 2 * BYTE_W;
    localparam int CTL_W  = 2;

    typedef enum logic {
        GUARD_OPEN = 1'b0,
        GUARD_HELD = 1'b1
    } guard_e;

    typedef struct packed {
        logic ie;
        logic lvl;
    } ctl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cmp_t;

    function automatic ctl_t decode_ctl(input logic [CTL_W-1:0] d);
        ctl_t c;
        c.lvl = d[0];
        c.ie  = d[1];
        return c;
    endfunction
endpackage

// File: rtl/ocmp_cmp_reg.sv
module ocmp_cmp_reg
    import ocmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output cmp_t              cmp_val,
    output logic              held
);
    cmp_t   cmp_q;
    guard_e guard_q;

    // compare bytes: no reset, no hardware update
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_hi) cmp_q.hi <= wr_data;
            else       cmp_q.lo <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 guard_q <= GUARD_OPEN;
        else if (wr_en && wr_hi) guard_q <= GUARD_HELD;
        else if (wr_en)          guard_q <= GUARD_OPEN;
    end

    assign cmp_val = cmp_q;
    assign held    = (guard_q == GUARD_HELD);

    // R6
    hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hi) |=> held);
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match
    import ocmp_pkg::*;
(
    input  cmp_t             cmp_val,
    input  logic [CMP_W-1:0] cnt_value,
    input  logic             cnt_tick,
    input  logic             held,
    output logic             match_evt
);
    logic equal;

    always_comb begin
        equal     = ({cmp_val.hi, cmp_val.lo} == cnt_value);
        match_evt = cnt_tick && !held && equal;
    end
endmodule

// File: rtl/ocmp_flag.sv
module ocmp_flag
    import ocmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             match_evt,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_data,
    input  logic             stat_rd,
    input  logic             lo_wr,
    output logic             flag,
    output logic             level_out,
    output logic             irq
);
    ctl_t ctl_q;
    logic flag_q;
    logic lvl_pin_q;
    logic arm_q;
    logic clr_now;

    assign clr_now = arm_q && lo_wr;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_wr) ctl_q <= decode_ctl(ctl_data);
    end

    always_ff @(posedge clk) begin
        if (rst)                  arm_q <= 1'b0;
        else if (lo_wr)           arm_q <= 1'b0;
        else if (stat_rd && flag_q) arm_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)            flag_q <= 1'b0;
        else if (match_evt) flag_q <= 1'b1;
        else if (clr_now)   flag_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)            lvl_pin_q <= 1'b0;
        else if (match_evt) lvl_pin_q <= ctl_q.lvl;
    end

    assign flag      = flag_q;
    assign level_out = lvl_pin_q;
    assign irq       = flag_q && ctl_q.ie;

    // R3
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(match_evt));
    // R5
    level_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (match_evt && !ctl_wr) |=> (lvl_pin_q == $past(ctl_q.lvl)));
    // R10
    match_wins_chk: assert property (@(posedge clk) disable iff (rst)
        match_evt |=> flag_q);
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
    import ocmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CMP_W-1:0]  cnt_value,
    input  logic              cnt_tick,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_data,
    input  logic              stat_rd,
    output logic [BYTE_W-1:0] rd_hi,
    output logic [BYTE_W-1:0] rd_lo,
    output logic              cmp_flag,
    output logic              level_out,
    output logic              irq
);
    cmp_t cmp_val;
    logic held;
    logic match_evt;
    logic lo_wr;

    assign lo_wr = wr_en && !wr_hi;

    ocmp_cmp_reg i_cmp_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .cmp_val (cmp_val),
        .held    (held)
    );

    ocmp_match i_match (
        .cmp_val   (cmp_val),
        .cnt_value (cnt_value),
        .cnt_tick  (cnt_tick),
        .held      (held),
        .match_evt (match_evt)
    );

    ocmp_flag i_flag (
        .clk       (clk),
        .rst       (rst),
        .match_evt (match_evt),
        .ctl_wr    (ctl_wr),
        .ctl_data  (ctl_data),
        .stat_rd   (stat_rd),
        .lo_wr     (lo_wr),
        .flag      (cmp_flag),
        .level_out (level_out),
        .irq       (irq)
    );

    assign rd_hi = cmp_val.hi;
    assign rd_lo = cmp_val.lo;

    // R6
    guard_block_chk: assert property (@(posedge clk) disable iff (rst)
        held |-> !match_evt);
    // R4
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_tick |-> !match_evt);
endmodule

// File: tb/test_ocmp_unit.sv
`timescale 1ns/1ps
module test_ocmp_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt_value = '0;
    logic        cnt_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        ctl_wr = 1'b0;
    logic [1:0]  ctl_data = '0;
    logic        stat_rd = 1'b0;
    logic [7:0]  rd_hi, rd_lo;
    logic        cmp_flag, level_out, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    ocmp_unit i_ocmp_unit (
        .clk(clk), .rst(rst), .cnt_value(cnt_value), .cnt_tick(cnt_tick),
        .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data), .ctl_wr(ctl_wr),
        .ctl_data(ctl_data), .stat_rd(stat_rd), .rd_hi(rd_hi), .rd_lo(rd_lo),
        .cmp_flag(cmp_flag), .level_out(level_out), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, outputs settled 1ns after posedge
    task automatic cyc(input bit we, input bit hi, input logic [7:0] d,
                       input bit cw, input logic [1:0] cd, input bit sr,
                       input bit tk, input logic [15:0] cv);
        @(negedge clk);
        wr_en = we; wr_hi = hi; wr_data = d; ctl_wr = cw; ctl_data = cd;
        stat_rd = sr; cnt_tick = tk; cnt_value = cv;
        @(posedge clk);
        #1;
        wr_en = 0; ctl_wr = 0; stat_rd = 0; cnt_tick = 0;
    endtask

    task automatic wr_byte(input bit hi, input logic [7:0] d);
        cyc(1, hi, d, 0, 2'b00, 0, 0, 16'h0);
    endtask
    task automatic wr_ctl(input logic [1:0] d);
        cyc(0, 0, 8'h0, 1, d, 0, 0, 16'h0);
    endtask
    task automatic tick(input logic [15:0] v);
        cyc(0, 0, 8'h0, 0, 2'b00, 0, 1, v);
    endtask
    task automatic stat();
        cyc(0, 0, 8'h0, 0, 2'b00, 1, 0, 16'h0);
    endtask

    // entry: {cmp, cnt, level bit, expect match}
    typedef struct packed {
        logic [15:0] cmp;
        logic [15:0] cnt;
        logic        lvl;
        logic        hit;
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'h1234, 16'h1234, 1'b1, 1'b1},
        '{16'h1234, 16'h1235, 1'b0, 1'b0},
        '{16'h00FF, 16'h00FF, 1'b0, 1'b1},
        '{16'hFFFF, 16'hFFFF, 1'b1, 1'b1},
        '{16'h8000, 16'h0080, 1'b0, 1'b0},
        '{16'h0000, 16'h0000, 1'b0, 1'b1}
    };

    initial begin
        logic exp_lvl;
        repeat (2) @(posedge clk);
        #1;
        // R2: reset state
        check("R2 flag", {15'b0, cmp_flag}, 16'h0);
        check("R2 level", {15'b0, level_out}, 16'h0);
        check("R2 irq", {15'b0, irq}, 16'h0);
        @(negedge clk); rst = 0;

        // R1: byte independence
        wr_byte(1, 8'h12); wr_byte(0, 8'h34);
        check("R1 readback", {rd_hi, rd_lo}, 16'h1234);
        wr_byte(1, 8'hAB);
        check("R1 hi only", {rd_hi, rd_lo}, 16'hAB34);
        wr_byte(0, 8'hCD);
        check("R1 lo only", {rd_hi, rd_lo}, 16'hABCD);

        // R2: bytes survive reset, guard released by reset
        wr_byte(1, 8'h55);
        @(negedge clk); rst = 1; @(posedge clk); #1; @(negedge clk); rst = 0;
        check("R2 bytes kept", {rd_hi, rd_lo}, 16'h55CD);
        tick(16'h55CD);
        check("R2 guard released", {15'b0, cmp_flag}, 16'h1);

        // R3 / R11 table walk
        exp_lvl = 1'b0;
        for (int i = 0; i < NV; i++) begin
            stat(); wr_byte(1, VECS[i].cmp[15:8]); wr_byte(0, VECS[i].cmp[7:0]);
            check("R9 cleared by sequence", {15'b0, cmp_flag}, 16'h0);
            wr_ctl({1'b0, VECS[i].lvl});
            tick(VECS[i].cnt);
            if (VECS[i].hit) exp_lvl = VECS[i].lvl;
            check("R3 flag", {15'b0, cmp_flag}, {15'b0, VECS[i].hit});
            check("R3 level", {15'b0, level_out}, {15'b0, exp_lvl});
        end

        // flag is set here (last vector hit), cmp = 0000, level 0
        // R9: low write without status read keeps flag
        wr_byte(0, 8'h00);
        check("R9 no read no clear", {15'b0, cmp_flag}, 16'h1);

        // R5: match while flag set still copies level
        wr_ctl(2'b01);
        tick(16'h0000);
        check("R5 level on repeat match", {15'b0, level_out}, 16'h1);
        check("R5 flag stays", {15'b0, cmp_flag}, 16'h1);

        // R4: equal but no tick
        stat(); wr_byte(0, 8'h00);
        check("R9 cleared", {15'b0, cmp_flag}, 16'h0);
        wr_ctl(2'b00);
        cyc(0, 0, 8'h0, 0, 2'b00, 0, 0, 16'h0000);
        check("R4 no tick flag", {15'b0, cmp_flag}, 16'h0);
        check("R4 no tick level", {15'b0, level_out}, 16'h1);

        // R6: high write holds matching until low write
        wr_byte(1, 8'h02);
        tick(16'h0200);
        check("R6 held no match", {15'b0, cmp_flag}, 16'h0);
        tick(16'h0200);
        check("R6 still held", {15'b0, cmp_flag}, 16'h0);
        wr_byte(0, 8'h00);
        tick(16'h0200);
        check("R6 released match", {15'b0, cmp_flag}, 16'h1);
        check("R6 level copied", {15'b0, level_out}, 16'h0);

        // R7: low write alone does not hold
        stat(); wr_byte(0, 8'h00);
        check("R7 cleared", {15'b0, cmp_flag}, 16'h0);
        wr_byte(0, 8'h00);
        tick(16'h0200);
        check("R7 match after lone low write", {15'b0, cmp_flag}, 16'h1);

        // R8: interrupt
        check("R8 irq off", {15'b0, irq}, 16'h0);
        wr_ctl(2'b10);
        check("R8 irq on", {15'b0, irq}, 16'h1);

        // R10: match and clearing write in same cycle
        stat();
        cyc(1, 0, 8'h00, 0, 2'b00, 0, 1, 16'h0200);
        check("R10 match wins", {15'b0, cmp_flag}, 16'h1);
        stat(); wr_byte(0, 8'h00);
        check("R8 irq drops with flag", {15'b0, irq}, 16'h0);
        wr_ctl(2'b00);
        tick(16'h0200);
        check("R8 irq masked", {15'b0, irq}, 16'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule